// File: doc/BRIEF.md
# Limited-to-Full Range Video Expander

This block takes a stream of video pixels, one sample per color channel per clock with a valid strobe, and stretches studio-range code values onto the full code range of the selected component depth. Each channel has the range floor removed, is scaled by a fixed-point gain equal to full span over studio span, is rounded to the nearest code and is then limited to the legal output codes. Component depth is 8, 10, 12 or 16 bits, chosen per sample by a two-bit select. Samples sit right-aligned in lanes that are DW bits wide.

Luma and RGB channels use the narrower studio range. When a color-space converter after this block is active (a per-sample flag), the lanes configured as chroma use the somewhat wider chroma studio range instead. With the enable low the block passes samples through untouched. The data, the valid strobe and the sync sideband all leave exactly two clocks after they enter, whatever the mode, so the block can sit in a pixel pipeline without retiming its neighbours.

Top module: `range_expand`

## Requirements
- R1: `cfg_depth` selects the component depth per sample: 0 is 8 bits, 1 is 10 bits, 2 is 12 bits, 3 is 16 bits; with s = depth minus 8, the studio floor is 16·2^s and the full-range maximum is 2^depth − 1.
- R2: On a lane that is not chroma, or on any lane while `cfg_csc` is 0, an input equal to the floor gives 0 and an input equal to 235·2^s + 2^s − 1 gives the full-range maximum.
- R3: On a chroma lane (lanes 1 and 2 by default) while `cfg_csc` is 1, the studio ceiling is 240·2^s + 2^s − 1 and maps to the full-range maximum, while the floor still maps to 0.
- R4: An input x strictly between floor F and ceiling C gives floor((2·(x − F)·M + L) / (2·L)), where L = C − F and M is the full-range maximum (round to nearest, halves upward).
- R5: An input at or below the floor gives 0.
- R6: An input at or above the ceiling gives the full-range maximum; no output ever exceeds it while enabled.
- R7: With `cfg_enable` low, every bit of every lane leaves unchanged, including bits above the selected depth.
- R8: `out_data`, `out_valid` and `out_sync` show the values belonging to the sample presented two rising edges earlier; configuration inputs are taken with that same sample, so they may change on every clock.
- R9: While `rst_n` is low, and at the first edge after its release, `out_valid`, `out_sync` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | 1 expands the range, 0 passes samples through |
| cfg_depth | input | 2 | Component depth select (0:8, 1:10, 2:12, 3:16 bits) |
| cfg_csc | input | 1 | Downstream color converter active: chroma lanes use the wider range |
| in_valid | input | 1 | Input sample valid |
| in_sync | input | SBW | Sync sideband (e.g. hsync, vsync, data enable) |
| in_data | input | NCH*DW | Input lanes, lane n in bits n*DW upward |
| out_valid | output | 1 | Output sample valid |
| out_sync | output | SBW | Sync sideband delayed with the data |
| out_data | output | NCH*DW | Output lanes |

## Verification
A wrong gain, floor or shift in one depth/chroma combination shows up as a code error on that lane at the output two clocks later, mostly near the midpoint and the ceiling, and the exhaustive 8- and 10-bit sweeps expose rounding slips of a single code. A stage register that loses its configuration or its bypass flag shows as a sample shaped under the previous sample's settings, which the back-to-back changes of mode and depth make visible at once. Any skew between data, valid and sync is visible as a sample arriving on the wrong cycle in the scoreboard, one clock off.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

   // fractional bits of the fixed-point gain; large enough that a gain
   // rounded upward never disturbs round-to-nearest on any 16-bit input
   localparam int FRAC = 34;
   // gain never reaches 2.0, so FRAC + 2 bits hold it
   localparam int GW   = FRAC + 2;

   typedef enum logic [1:0] {
      DEPTH_8  = 2'd0,
      DEPTH_10 = 2'd1,
      DEPTH_12 = 2'd2,
      DEPTH_16 = 2'd3
   } depth_e;

   function automatic int unsigned bits_of(depth_e d);
      case (d)
         DEPTH_8:  return 8;
         DEPTH_10: return 10;
         DEPTH_12: return 12;
         default:  return 16;
      endcase
   endfunction

   function automatic longint unsigned floor_of(depth_e d);
      return 64'd16 << (bits_of(d) - 8);
   endfunction

   function automatic longint unsigned ceil_of(depth_e d, logic wide);
      longint unsigned unit;
      longint unsigned top;
      unit = 64'd1 << (bits_of(d) - 8);
      top  = wide ? 64'd240 : 64'd235;
      return top * unit + unit - 64'd1;
   endfunction

   function automatic longint unsigned max_of(depth_e d);
      return (64'd1 << bits_of(d)) - 64'd1;
   endfunction

   // ceil(max * 2^FRAC / span)
   function automatic longint unsigned gain_of(depth_e d, logic wide);
      longint unsigned span;
      longint unsigned num;
      span = ceil_of(d, wide) - floor_of(d);
      num  = max_of(d) << FRAC;
      return (num + span - 64'd1) / span;
   endfunction

endpackage

// File: rtl/rxp_coef.sv
module rxp_coef #(
   parameter int DW = 16
) (
   input  logic [1:0]               depth,
   input  logic                     wide,
   output logic [DW-1:0]            floor_code,
   output logic [DW-1:0]            max_code,
   output logic [rxp_pkg::GW-1:0]   gain
);
   import rxp_pkg::*;

   depth_e dsel;
   assign dsel = depth_e'(depth);

   always_comb begin
      floor_code = DW'(floor_of(dsel));
      max_code   = DW'(max_of(dsel));
      gain       = GW'(gain_of(dsel, wide));
   end

endmodule

// File: rtl/rxp_lane.sv
module rxp_lane #(
   parameter int DW     = 16,
   parameter bit CHROMA = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [1:0]    depth,
   input  logic          csc,
   input  logic [DW-1:0] x,
   output logic [DW-1:0] y
);
   import rxp_pkg::*;

   localparam int PW = DW + GW;
   localparam logic [PW-1:0] HALF = PW'(64'd1 << (FRAC - 1));

   logic wide;
   generate
      if (CHROMA) begin : g_chroma
         assign wide = csc;
      end else begin : g_luma
         assign wide = 1'b0;
      end
   endgenerate

   logic [DW-1:0] c_floor, c_max;
   logic [GW-1:0] c_gain;

   rxp_coef #(.DW(DW)) u_coef (
      .depth      (depth),
      .wide       (wide),
      .floor_code (c_floor),
      .max_code   (c_max),
      .gain       (c_gain)
   );

   // stage 1: offset removal, coefficient capture
   logic          s1_byp;
   logic [DW-1:0] s1_raw, s1_diff, s1_max;
   logic [GW-1:0] s1_gain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_byp  <= 1'b0;
         s1_raw  <= '0;
         s1_diff <= '0;
         s1_max  <= '0;
         s1_gain <= '0;
      end else begin
         s1_byp  <= !en;
         s1_raw  <= x;
         s1_diff <= (x < c_floor) ? '0 : x - c_floor;
         s1_max  <= c_max;
         s1_gain <= c_gain;
      end
   end

   // stage 2: scale, round, clamp, bypass select
   logic [PW-1:0] prod, rnd;
   logic [DW-1:0] sat;

   always_comb begin
      prod = PW'(s1_diff) * PW'(s1_gain);
      rnd  = (prod + HALF) >> FRAC;
      sat  = (rnd > PW'(s1_max)) ? s1_max : rnd[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) y <= '0;
      else        y <= s1_byp ? s1_raw : sat;
   end

endmodule

// File: rtl/rxp_delay.sv
module rxp_delay #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] tap [STAGES+1];
   assign tap[0] = d;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tap[i+1] <= '0;
            else        tap[i+1] <= tap[i];
         end
      end
   endgenerate

   assign q = tap[STAGES];

endmodule

// File: rtl/range_expand.sv
module range_expand #(
   parameter int           NCH         = 3,
   parameter int           DW          = 16,
   parameter int           SBW         = 3,
   parameter logic [NCH-1:0] CHROMA_MASK = 3'b110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [1:0]        cfg_depth,
   input  logic              cfg_csc,
   input  logic              in_valid,
   input  logic [SBW-1:0]    in_sync,
   input  logic [NCH*DW-1:0] in_data,
   output logic              out_valid,
   output logic [SBW-1:0]    out_sync,
   output logic [NCH*DW-1:0] out_data
);
   localparam int LATENCY = 2;
   localparam int SIDE_W  = SBW + 1;

   generate
      if (DW < 16) begin : g_bad_dw
         $error("range_expand: DW must hold a 16-bit component");
      end
      if (NCH < 1) begin : g_bad_nch
         $error("range_expand: NCH must be at least 1");
      end
      if (SBW < 1) begin : g_bad_sbw
         $error("range_expand: SBW must be at least 1");
      end
   endgenerate

   generate
      for (genvar l = 0; l < NCH; l++) begin : g_lane
         rxp_lane #(.DW(DW), .CHROMA(CHROMA_MASK[l])) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cfg_enable),
            .depth (cfg_depth),
            .csc   (cfg_csc),
            .x     (in_data[l*DW +: DW]),
            .y     (out_data[l*DW +: DW])
         );
      end
   endgenerate

   logic [SIDE_W-1:0] side_q;

   rxp_delay #(.W(SIDE_W), .STAGES(LATENCY)) u_side (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({in_valid, in_sync}),
      .q     (side_q)
   );

   assign out_valid = side_q[SIDE_W-1];
   assign out_sync  = side_q[SBW-1:0];

endmodule

// File: rtl/range_expand_chk.sv
module range_expand_chk #(
   parameter int             NCH         = 3,
   parameter int             DW          = 16,
   parameter int             SBW         = 3,
   parameter logic [NCH-1:0] CHROMA_MASK = 3'b110
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_enable,
   input logic [1:0]        cfg_depth,
   input logic              cfg_csc,
   input logic              in_valid,
   input logic [SBW-1:0]    in_sync,
   input logic [NCH*DW-1:0] in_data,
   input logic              out_valid,
   input logic [SBW-1:0]    out_sync,
   input logic [NCH*DW-1:0] out_data
);
   import rxp_pkg::*;

   // edges seen since reset release, saturating at 2
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age <= 2'd0;
      else if (age != 2'd2)  age <= age + 2'd1;
   end

   logic [DW-1:0] max_now;
   assign max_now = DW'(max_of(depth_e'(cfg_depth)));

   AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R8

   AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (out_sync == $past(in_sync, 2))); // R8

   AST_FIRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd0) |-> (!out_valid && out_data == '0)); // R9

   generate
      for (genvar l = 0; l < NCH; l++) begin : g_lane
         logic [DW-1:0] floor_now;
         assign floor_now = DW'(floor_of(depth_e'(cfg_depth)));

         AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd2 && !$past(cfg_enable, 2))
            |-> (out_data[l*DW +: DW] == $past(in_data[l*DW +: DW], 2))); // R7

         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd2 && $past(cfg_enable, 2))
            |-> (out_data[l*DW +: DW] <= $past(max_now, 2))); // R6

         AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd2 && $past(cfg_enable, 2)
             && $past(in_data[l*DW +: DW], 2) <= $past(floor_now, 2))
            |-> (out_data[l*DW +: DW] == '0)); // R5
      end
   endgenerate

endmodule

bind range_expand range_expand_chk #(
   .NCH(NCH), .DW(DW), .SBW(SBW), .CHROMA_MASK(CHROMA_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_enable (cfg_enable),
   .cfg_depth  (cfg_depth),
   .cfg_csc    (cfg_csc),
   .in_valid   (in_valid),
   .in_sync    (in_sync),
   .in_data    (in_data),
   .out_valid  (out_valid),
   .out_sync   (out_sync),
   .out_data   (out_data)
);

// File: tb/range_expand_test.sv
`timescale 1ns/1ps
module range_expand_test;
   localparam int NCH = 3;
   localparam int DW  = 16;
   localparam int SBW = 3;
   localparam logic [NCH-1:0] CMASK = 3'b110;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_enable = 1'b0;
   logic [1:0]        cfg_depth = 2'd0;
   logic              cfg_csc = 1'b0;
   logic              in_valid = 1'b0;
   logic [SBW-1:0]    in_sync = '0;
   logic [NCH*DW-1:0] in_data = '0;
   logic              out_valid;
   logic [SBW-1:0]    out_sync;
   logic [NCH*DW-1:0] out_data;

   always #2.5 clk = ~clk;

   range_expand #(.NCH(NCH), .DW(DW), .SBW(SBW), .CHROMA_MASK(CMASK)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_depth(cfg_depth),
      .cfg_csc(cfg_csc), .in_valid(in_valid), .in_sync(in_sync), .in_data(in_data),
      .out_valid(out_valid), .out_sync(out_sync), .out_data(out_data)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit ended  = 0;

   always @(posedge clk) cyc = cyc + 1;

   typedef struct {
      logic [NCH*DW-1:0] data;
      logic [SBW-1:0]    sync;
      int                due;
      string             tag;
   } exp_t;
   exp_t sb[$];

   // reference model, written from the requirements
   function automatic longint unsigned unit_of(int d);
      return longint'(1) << (2 * d + (d == 3 ? 2 : 0));   // 1,4,16,256
   endfunction
   function automatic longint unsigned lo_ref(int d);
      return 16 * unit_of(d);
   endfunction
   function automatic longint unsigned hi_ref(int d, bit wide);
      return (wide ? 240 : 235) * unit_of(d) + unit_of(d) - 1;
   endfunction
   function automatic longint unsigned top_ref(int d);
      return 255 * unit_of(d) + unit_of(d) - 1;
   endfunction
   function automatic logic [DW-1:0] model(bit en, int d, bit wide, logic [DW-1:0] x);
      longint unsigned lo, hi, mx, span, v;
      if (!en) return x;
      lo = lo_ref(d); hi = hi_ref(d, wide); mx = top_ref(d);
      v  = longint'(x);
      if (v <= lo) return '0;
      if (v >= hi) return DW'(mx);
      span = hi - lo;
      return DW'((2 * (v - lo) * mx + span) / (2 * span));
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   task automatic send(bit en, int d, bit csc, logic [DW-1:0] x0, logic [DW-1:0] x1,
                       logic [DW-1:0] x2, string tag);
      exp_t e;
      logic [DW-1:0] xs [NCH];
      xs[0] = x0; xs[1] = x1; xs[2] = x2;
      @(negedge clk);
      cfg_enable = en; cfg_depth = 2'(d); cfg_csc = csc;
      in_valid = 1'b1;
      in_sync  = SBW'(cyc);
      for (int l = 0; l < NCH; l++) begin
         in_data[l*DW +: DW] = xs[l];
         e.data[l*DW +: DW] = model(en, d, CMASK[l] && csc, xs[l]);
      end
      e.sync = SBW'(cyc);
      e.due  = cyc + 2;
      e.tag  = tag;
      sb.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = {NCH{16'hDEAD}};
         in_sync  = '1;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (!out_valid || out_data !== e.data || out_sync !== e.sync) begin
               fails++;
               $display("FAIL %s (R8 timing): valid=%b data=%h sync=%h exp valid=1 data=%h sync=%h",
                        e.tag, out_valid, out_data, out_sync, e.data, e.sync);
            end
         end else if (out_valid) begin
            checks++; fails++;
            $display("FAIL R8: unexpected out_valid act=1 exp=0 at cycle %0d", cyc);
         end
      end
   end

   task automatic reset_check(string when);
      checks++;
      if (out_valid !== 1'b0 || out_data !== '0 || out_sync !== '0) begin
         fails++;
         $display("FAIL R9 (%s): valid=%b data=%h sync=%h exp all zero",
                  when, out_valid, out_data, out_sync);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      checks++; fails++;
      $display("FAIL watchdog: run did not complete act=hung exp=done");
      finish_run();
   end

   initial begin
      logic [DW-1:0] xs [NCH];
      // reset with live inputs: outputs must stay idle (R9)
      in_valid = 1'b1; in_data = {NCH{16'hFFFF}}; in_sync = '1; cfg_enable = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); reset_check("in reset");
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk); reset_check("after release");

      // endpoints, midpoint, outside values per depth and chroma mode (R1..R6)
      for (int d = 0; d < 4; d++) begin
         for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 7; k++) begin
               string tag;
               for (int l = 0; l < NCH; l++) begin
                  bit w;
                  longint unsigned lo, hi;
                  w  = CMASK[l] && (c == 1);
                  lo = lo_ref(d); hi = hi_ref(d, w);
                  case (k)
                     0: xs[l] = DW'(lo);
                     1: xs[l] = DW'(hi);
                     2: xs[l] = DW'((lo + hi) / 2);
                     3: xs[l] = DW'(lo - 1);
                     4: xs[l] = DW'(hi + 1);
                     5: xs[l] = '0;
                     default: xs[l] = top_ref(d) == 65535 ? 16'hFFFF : DW'(top_ref(d));
                  endcase
               end
               case (k)
                  0: tag = (c == 1) ? "R1 R3 floor" : "R1 R2 floor";
                  1: tag = (c == 1) ? "R1 R3 ceiling" : "R1 R2 ceiling";
                  2: tag = "R4 midpoint";
                  3, 5: tag = "R5 below floor";
                  default: tag = "R6 above ceiling";
               endcase
               send(1'b1, d, c == 1, xs[0], xs[1], xs[2], tag);
               if (k == 3) idle(1);
            end
            idle(c + 1);
         end
      end

      // exhaustive 8-bit with chroma range, 10-bit with luma range (R4)
      for (int v = 0; v < 256; v++) send(1'b1, 0, 1'b1, 16'(v), 16'(v), 16'(v), "R4 sweep8");
      idle(2);
      for (int v = 0; v < 1024; v++) send(1'b1, 1, 1'b0, 16'(v), 16'(v), 16'(v), "R4 sweep10");
      for (int v = 0; v < 4096; v += 13) send(1'b1, 2, 1'b1, 16'(v), 16'(v), 16'(v), "R4 sweep12");
      for (int v = 0; v < 65536; v += 263) send(1'b1, 3, v[0], 16'(v), 16'(v ^ 16'h0F0F), 16'(v), "R4 sweep16");

      // bypass, all bits preserved (R7)
      send(1'b0, 0, 1'b1, 16'hA5C3, 16'hFFFF, 16'h0001, "R7 bypass");
      send(1'b0, 3, 1'b0, 16'h0000, 16'h1234, 16'hEDCB, "R7 bypass");
      idle(1);

      // per-sample configuration changes back to back (R8)
      for (int i = 0; i < 40; i++) begin
         send(i[0], i % 4, i[1], 16'(i * 1601), 16'(i * 977 + 5), 16'(65535 - i * 1499), "R8 per-sample cfg");
      end
      idle(6);
      wait (sb.size() == 0);
      idle(3);
      finish_run();
   end

endmodule